// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the slave side of a two-wire (I2C) serial memory. It runs from a fast system clock and samples SCL and SDA through synchronizers, detecting START and STOP conditions and bit edges. It serves a small byte-wide register array on the chip. A master addresses it with a device byte, can set a word address, and then writes a burst of bytes or reads a stream of bytes back.

The device byte has a fixed four-bit prefix, three select bits and a read/write flag. A density parameter `INT_BITS` decides how many of the three select bits act as upper memory address bits. The rest are compared against the `dev_pins` strap inputs, so several instances can share one bus. A write-protect input blocks every change to the array. SDA is only ever pulled low or released: the block drives a single enable, `sda_oe`, and the pad pulls the wire low while that enable is high.

Top module: `i2c_mem_slave`

## Requirements
- R1: After reset `sda_oe` is low. Bus clocks sent before any START get no acknowledge and leave the memory unchanged.
- R2: A device byte is accepted only when bits 7:4 are 1010 and bits 3:2 equal `dev_pins[2:1]` (with the default INT_BITS=1). On a mismatch the slave gives no acknowledge and ignores all traffic until the next START.
- R3: The slave pulls SDA low during the 9th SCL clock after an accepted device byte and after every byte of a write.
- R4: In a write (device byte bit 0 = 0), device byte bit 1 becomes address bit 8 and the next byte becomes address bits 7:0. The following bytes are stored at successive addresses.
- R5: In a read (device byte bit 0 = 1), data goes out MSB first and `sda_oe` changes only while SCL is low. The next byte follows while the master acknowledges. After a NoACK the slave drives nothing.
- R6: While `wp` is high, write bytes are still acknowledged but the memory keeps its contents.
- R7: The address steps by one after each byte read or written, carries from bit 7 into bit 8, and wraps from 511 to 0.
- R8: A read with no address phase starts at the address after the last byte accessed. A rejected device byte does not move that address.
- R9: A START in any state, including in the middle of a byte, restarts reception of the device byte.
- R10: A STOP ends the command. Bytes that follow it without a new START get no acknowledge and cause no write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| dev_pins | input | 3 | Strap inputs compared with the select bits that are not used as address bits |
| wp | input | 1 | Write protect, high blocks writes to the array |
| sda_oe | output | 1 | High pulls SDA low (open drain) |

## Verification
The hardest states to reach are the ones where a transaction is broken off rather than completed. Examples are a START arriving four bits into a device byte, data bytes clocked after a rejected address, and a bus released only after the master's NoACK. Directed sequences build each of these by hand from a bit-level bus driver. A fixed-seed random mix of bursts then follows, with random start addresses, lengths and write-protect settings and both kinds of read. A bench model of the array and its address pointer predicts every acknowledge and every returned byte.

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave #(
  parameter int INT_BITS = 1,
  parameter logic [3:0] DEV_PREFIX = 4'b1010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] dev_pins,
  input  logic       wp,
  output logic       sda_oe
);
  localparam int AW = 8 + INT_BITS;
  localparam int DEPTH = 1 << AW;
  localparam logic [2:0] INT_MASK = 3'((1 << INT_BITS) - 1);
  localparam logic [2:0] ST_IDLE = 3'd0, ST_DEV = 3'd1, ST_ADDR = 3'd2,
                         ST_WR = 3'd3, ST_RD = 3'd4;

  logic [2:0] scl_p, sda_p;
  logic [2:0] st;
  logic [3:0] cnt;
  logic [7:0] sr;
  logic [AW-1:0] addr;
  logic [2:0] page;
  logic [7:0] mem [DEPTH];
  logic [7:0] rd_byte;
  logic [10:0] full_addr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_p <= 3'b111;
      sda_p <= 3'b111;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end

  wire scl_s    = scl_p[1];
  wire sda_s    = sda_p[1];
  wire scl_rise = scl_s & ~scl_p[2];
  wire scl_fall = ~scl_s & scl_p[2];
  wire bus_hi   = scl_s & scl_p[2];
  wire start_c  = bus_hi & sda_p[2] & ~sda_s;
  wire stop_c   = bus_hi & ~sda_p[2] & sda_s;
  wire dev_ok   = (sr[7:4] == DEV_PREFIX) && (((sr[3:1] ^ dev_pins) & ~INT_MASK) == 3'b000);
  wire mem_we   = (st == ST_WR) && scl_fall && (cnt == 4'd8) && !wp;

  assign rd_byte   = mem[addr];
  assign full_addr = {page, sr};

  always_ff @(posedge clk)
    if (mem_we) mem[addr] <= sr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      sr     <= '0;
      addr   <= '0;
      page   <= '0;
      sda_oe <= 1'b0;
    end else if (start_c) begin
      st     <= ST_DEV;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (stop_c) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (st != ST_IDLE) begin
      if (scl_rise) begin
        if (cnt != 4'd8) begin
          cnt <= cnt + 4'd1;
          if (st != ST_RD) sr <= {sr[6:0], sda_s};
        end else begin
          cnt <= '0;
          case (st)
            ST_DEV:  st <= sr[0] ? ST_RD : ST_ADDR;
            ST_ADDR: st <= ST_WR;
            ST_RD:   if (sda_s) st <= ST_IDLE;
            default: ;
          endcase
        end
      end else if (scl_fall) begin
        if (cnt == 4'd8) begin
          case (st)
            ST_DEV:
              if (dev_ok) begin
                sda_oe <= 1'b1;
                page   <= sr[3:1] & INT_MASK;
              end else st <= ST_IDLE;
            ST_ADDR: begin
              sda_oe <= 1'b1;
              addr   <= full_addr[AW-1:0];
            end
            ST_WR: begin
              sda_oe <= 1'b1;
              addr   <= addr + 1'b1;
            end
            ST_RD: begin
              sda_oe <= 1'b0;
              addr   <= addr + 1'b1;
            end
            default: ;
          endcase
        end else if (st == ST_RD) sda_oe <= ~rd_byte[~cnt[2:0]];
        else sda_oe <= 1'b0;
      end
    end
endmodule

// File: rtl/i2c_mem_slave_chk.sv
module i2c_mem_slave_chk #(
  parameter int AW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sda_oe,
  input logic          scl_s,
  input logic          start_c,
  input logic          stop_c,
  input logic [2:0]    st,
  input logic [3:0]    cnt,
  input logic [AW-1:0] addr
);
  localparam logic [2:0] ST_IDLE = 3'd0, ST_DEV = 3'd1, ST_RD = 3'd4;

  p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sda_oe);

  p_bit_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= 4'd8);

  p_oe_scl_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> (!$past(scl_s) || $past(start_c) || $past(stop_c)));

  p_addr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_RD) && ($past(st) == ST_RD) && (addr != $past(addr)))
      |-> (addr == AW'($past(addr) + 1'b1)));

  p_start_dev_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> (st == ST_DEV && cnt == 4'd0));
endmodule

bind i2c_mem_slave i2c_mem_slave_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_s(scl_s),
  .start_c(start_c), .stop_c(stop_c), .st(st), .cnt(cnt), .addr(addr)
);

// File: tb/sim_i2c_mem_slave.sv
`timescale 1ns/1ps
module sim_i2c_mem_slave;
  localparam int Q = 3;
  localparam logic [2:0] PINS = 3'b101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic wp = 1'b0;
  logic sda_oe;
  wire  bus = sda_m & ~sda_oe;

  int nchk = 0;
  int nerr = 0;
  logic [7:0] ref_mem [512];
  logic [8:0] ref_addr = '0;

  always #10 clk = ~clk;

  i2c_mem_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(bus),
    .dev_pins(PINS), .wp(wp), .sda_oe(sda_oe)
  );

  function automatic logic [7:0] dev_byte(input logic a8, input logic rw);
    return {4'b1010, PINS[2:1], a8, rw};
  endfunction

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_io(input logic b, output logic s);
    scl = 1'b0; hc(Q);
    sda_m = b;  hc(Q);
    scl = 1'b1; hc(Q);
    s = bus;    hc(Q);
  endtask

  task automatic start_cond();
    scl = 1'b0; hc(Q);
    sda_m = 1'b1; hc(Q);
    scl = 1'b1; hc(Q);
    sda_m = 1'b0; hc(Q);
  endtask

  task automatic stop_cond();
    scl = 1'b0; hc(Q);
    sda_m = 1'b0; hc(Q);
    scl = 1'b1; hc(Q);
    sda_m = 1'b1; hc(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) bit_io(b[i], s);
    bit_io(1'b1, s);
    acked = ~s;
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_io(1'b1, s);
      b[i] = s;
    end
    bit_io(nack, s);
  endtask

  task automatic wr_burst(input logic [8:0] a, input int n, input logic prot);
    logic ak;
    logic [7:0] d;
    wp = prot;
    start_cond();
    send_byte(dev_byte(a[8], 1'b0), ak);
    check(ak, "R3 device ack", ak, 1);
    send_byte(a[7:0], ak);
    check(ak, "R3 address ack", ak, 1);
    ref_addr = a;
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      send_byte(d, ak);
      check(ak, prot ? "R6 protected byte ack" : "R4 data ack", ak, 1);
      if (!prot) ref_mem[ref_addr] = d;
      ref_addr = ref_addr + 9'd1;
    end
    stop_cond();
    wp = 1'b0;
  endtask

  task automatic rd_stream(input int n);
    logic [7:0] d;
    for (int i = 0; i < n; i++) begin
      recv_byte(i == n - 1, d);
      check(d == ref_mem[ref_addr], "R5/R7 read data", d, ref_mem[ref_addr]);
      ref_addr = ref_addr + 9'd1;
    end
  endtask

  task automatic rd_rand(input logic [8:0] a, input int n);
    logic ak;
    start_cond();
    send_byte(dev_byte(a[8], 1'b0), ak);
    check(ak, "R3 device ack", ak, 1);
    send_byte(a[7:0], ak);
    check(ak, "R3 address ack", ak, 1);
    ref_addr = a;
    start_cond();
    send_byte(dev_byte(1'b0, 1'b1), ak);
    check(ak, "R5 read device ack", ak, 1);
    rd_stream(n);
    stop_cond();
  endtask

  task automatic rd_cur(input int n, input string tag);
    logic ak;
    start_cond();
    send_byte(dev_byte(1'b0, 1'b1), ak);
    check(ak, tag, ak, 1);
    rd_stream(n);
    stop_cond();
  endtask

  task automatic loose_byte(input logic [7:0] b, input string tag);
    logic ak;
    send_byte(b, ak);
    check(!ak, tag, ak, 0);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog R1-chain actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    logic ak;
    logic s;
    logic [7:0] d1, d2, ox;
    void'($urandom(32'd20240611));
    hc(5);
    rst_n = 1'b1;
    hc(3);
    check(sda_oe == 1'b0, "R1 reset release", sda_oe, 0);

    // R1: bytes before any START
    loose_byte(dev_byte(1'b0, 1'b0), "R1 no ack without start");
    loose_byte(8'h00, "R1 no ack without start");
    stop_cond();

    // R4: fill the whole array
    wr_burst(9'h000, 512, 1'b0);
    // R7: carry from bit 7 into bit 8
    rd_rand(9'h0FD, 5);
    // R7: wrap at the top
    wr_burst(9'h1FE, 4, 1'b0);
    rd_rand(9'h1FE, 4);
    // R8: current address read
    rd_cur(3, "R8 current read ack");

    // R6: write protect
    wr_burst(9'h040, 3, 1'b1);
    rd_rand(9'h040, 3);

    // R2: pin mismatch, then wrong prefix
    start_cond();
    loose_byte({4'b1010, ~PINS[2:1], 2'b00}, "R2 pin mismatch no ack");
    loose_byte(8'h55, "R2 ignored after mismatch");
    stop_cond();
    start_cond();
    loose_byte({4'b1011, PINS[2:1], 2'b00}, "R2 prefix mismatch no ack");
    loose_byte(8'hAA, "R2 ignored after mismatch");
    stop_cond();
    rd_cur(1, "R8 address kept after mismatch");

    // R10: stop ends a write, then bytes without START
    wr_burst(9'h080, 1, 1'b0);
    loose_byte(8'h12, "R10 no ack after stop");
    loose_byte(8'h34, "R10 no ack after stop");
    stop_cond();
    rd_rand(9'h080, 3);

    // R9: repeated start after a byte and inside a byte
    d1 = 8'($urandom);
    d2 = 8'($urandom);
    start_cond();
    send_byte(dev_byte(1'b0, 1'b0), ak);
    send_byte(8'h20, ak);
    send_byte(d1, ak);
    ref_mem[9'h020] = d1;
    start_cond();
    send_byte(dev_byte(1'b0, 1'b0), ak);
    check(ak, "R9 ack after repeated start", ak, 1);
    for (int i = 0; i < 4; i++) bit_io(1'b0, s);
    start_cond();
    send_byte(dev_byte(1'b0, 1'b0), ak);
    check(ak, "R9 ack after mid-byte start", ak, 1);
    send_byte(8'h30, ak);
    send_byte(d2, ak);
    ref_mem[9'h030] = d2;
    stop_cond();
    rd_rand(9'h01F, 3);
    rd_rand(9'h030, 1);

    // R5: after NoACK the slave stays off the bus
    start_cond();
    send_byte(dev_byte(1'b0, 1'b1), ak);
    recv_byte(1'b1, ox);
    check(ox == ref_mem[ref_addr], "R5 read before nack", ox, ref_mem[ref_addr]);
    ref_addr = ref_addr + 9'd1;
    for (int i = 0; i < 9; i++) begin
      bit_io(1'b1, s);
      check(s == 1'b1, "R5 released after nack", s, 1);
    end
    stop_cond();
    rd_cur(2, "R8 continue after nack");

    // random mix
    for (int k = 0; k < 30; k++) begin
      int op = int'($urandom % 3);
      logic [8:0] a = 9'($urandom);
      int n = 1 + int'($urandom % 5);
      case (op)
        0: wr_burst(a, n, ($urandom % 4) == 0);
        1: rd_rand(a, n);
        default: rd_cur(n, "R8 current read ack");
      endcase
    end

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule